// File: doc/BRIEF.md
# Load Way-Prediction Trust Table

This block decides, for each load, whether the cache's way guess deserves to be trusted. It is a direct-mapped store of small saturating counters with no tag. The front end indexes it with the low bits of the load's program counter. Each lookup returns a single trust bit one cycle later. That bit travels with the load to issue. The same bit is used in two places: the scheduler uses it to pick early or delayed wakeup of dependent instructions, and the cache uses it to turn the speculative single-way probe on or off.

Outcomes come back later on update ports. Each update says whether the guess for one load was right. A counter rises on a right guess and falls on a wrong one. A mode pin selects one of two policies. In the balanced policy, steps are symmetric and the upper half of the counter range is trusted. In the guarded policy, a wrong guess costs twice as much and only a saturated counter is trusted, so the table trusts a bad guess far less often.

There are several independent lookup ports and several update ports. Lookup and update channels are valid-qualified streams with no ready signal: the table accepts a beat on every cycle and never applies back-pressure. Only beats marked as loads act on the table. The mode pin and reset are plain control inputs.

Top module: `conf_trust_table`

## Requirements
- R1: After reset every counter holds 0, so every lookup reports untrusted until the entry has been trained.
- R2: With bias_mode=0, a load update with up_correct=1 raises the addressed counter by 1 and one with up_correct=0 lowers it by 1. The counter stays within 0 and 3.
- R3: With bias_mode=0, a lookup reports trust=1 exactly when the counter is 2 or 3.
- R4: With bias_mode=1, a correct outcome raises the counter by 1 and a wrong outcome lowers it by 2. The counter saturates at 3 and clamps at 0, so a wrong outcome at 1 gives 0.
- R5: With bias_mode=1, a lookup reports trust=1 only when the counter is 3.
- R6: A lookup beat on port i (lk_valid[i]=1 and lk_load[i]=1) produces rsp_valid[i]=1 and its trust on rsp_trust[i] on the next cycle. Port i uses index field lk_idx[i*IDX_W +: IDX_W]. Update port j uses up_idx[j*IDX_W +: IDX_W].
- R7: A lookup in the same cycle as an update to the same entry returns the trust from the counter value before that update.
- R8: Two updates to one entry in the same cycle are applied in port order, port 0 first and then port 1, in the mode active that cycle.
- R9: A lookup beat with lk_load=0 gives rsp_valid=0 and rsp_trust=0. An update with up_load=0 leaves the counters unchanged. A counter changes only through load updates to its own index.
- R10: The lookup ports work independently. They may address any indices, including the same one, and two ports reading the same entry in one cycle get the same answer.
- R11: Changing bias_mode changes how the next lookups are judged but does not alter the stored counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bias_mode | input | 1 | 0 selects the balanced policy, 1 selects the guarded policy |
| lk_valid | input | N_RD | Lookup beat present, one bit per port |
| lk_load | input | N_RD | Beat belongs to a load, one bit per port |
| lk_idx | input | N_RD*IDX_W | Low PC bits for each lookup port |
| rsp_valid | output | N_RD | Trust result present, one cycle after a load lookup |
| rsp_trust | output | N_RD | Trust bit for each lookup port |
| up_valid | input | N_WR | Update beat present, one bit per port |
| up_load | input | N_WR | Update belongs to a load, one bit per port |
| up_idx | input | N_WR*IDX_W | Low PC bits for each update port |
| up_correct | input | N_WR | 1 when the way guess was right |

## Verification
The bench builds the table with IDX_W=4, which gives 16 entries, and keeps two lookup ports and two update ports with 2-bit counters and a guarded step of 2. The small table lets short directed sequences drive single entries through full saturation and clamping in both policies. It also covers two updates colliding on one entry, a lookup colliding with an update, and both lookup ports landing on the same entry. Counter values that trust bits alone cannot show are read out by switching the mode between lookups.

// File: rtl/cnf_pkg.sv
package cnf_pkg;
  typedef enum logic {
    MODE_BALANCED = 1'b0,
    MODE_GUARDED  = 1'b1
  } trust_mode_e;
endpackage

// File: rtl/cnf_entry.sv
module cnf_entry #(
  parameter int IDX_W    = 8,
  parameter int N_WR     = 2,
  parameter int CTR_W    = 2,
  parameter int BIAS_DEC = 2,
  parameter int SLOT     = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cnf_pkg::trust_mode_e    mode,
  input  logic [N_WR-1:0]         wr_en,
  input  logic [N_WR*IDX_W-1:0]   wr_idx,
  input  logic [N_WR-1:0]         wr_ok,
  output logic [CTR_W-1:0]        ctr_q
);
  localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(SLOT);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;

  logic [CTR_W-1:0] dec_step;
  logic [CTR_W-1:0] ctr_d;

  assign dec_step = (mode == cnf_pkg::MODE_GUARDED) ? CTR_W'(BIAS_DEC) : CTR_W'(1);

  // updates fold in port order so a collision has one defined result
  always_comb begin
    ctr_d = ctr_q;
    for (int p = 0; p < N_WR; p++) begin
      if (wr_en[p] && (wr_idx[p*IDX_W +: IDX_W] == SLOT_IDX)) begin
        if (wr_ok[p]) begin
          if (ctr_d != CTR_MAX) ctr_d = ctr_d + CTR_W'(1);
        end else if (ctr_d < dec_step) begin
          ctr_d = '0;
        end else begin
          ctr_d = ctr_d - dec_step;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end
endmodule

// File: rtl/cnf_read_port.sv
module cnf_read_port #(
  parameter int IDX_W = 8,
  parameter int CTR_W = 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cnf_pkg::trust_mode_e     mode,
  input  logic                     req_valid,
  input  logic                     req_load,
  input  logic [IDX_W-1:0]         req_idx,
  input  logic [ENTRIES*CTR_W-1:0] tbl,
  output logic                     rsp_valid,
  output logic                     rsp_trust
);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_HALF = CTR_W'(1) << (CTR_W - 1);

  logic [CTR_W-1:0] sel;
  logic             trust_now;
  logic             take;

  assign sel       = tbl[int'(req_idx)*CTR_W +: CTR_W];
  assign trust_now = (mode == cnf_pkg::MODE_GUARDED) ? (sel == CTR_MAX) : (sel >= CTR_HALF);
  assign take      = req_valid && req_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_trust <= 1'b0;
    end else begin
      rsp_valid <= take;
      rsp_trust <= take && trust_now;
    end
  end
endmodule

// File: rtl/conf_trust_table.sv
module conf_trust_table #(
  parameter int IDX_W    = 8,
  parameter int N_RD     = 2,
  parameter int N_WR     = 2,
  parameter int CTR_W    = 2,
  parameter int BIAS_DEC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bias_mode,
  input  logic [N_RD-1:0]       lk_valid,
  input  logic [N_RD-1:0]       lk_load,
  input  logic [N_RD*IDX_W-1:0] lk_idx,
  output logic [N_RD-1:0]       rsp_valid,
  output logic [N_RD-1:0]       rsp_trust,
  input  logic [N_WR-1:0]       up_valid,
  input  logic [N_WR-1:0]       up_load,
  input  logic [N_WR*IDX_W-1:0] up_idx,
  input  logic [N_WR-1:0]       up_correct
);
  localparam int ENTRIES = 1 << IDX_W;

  cnf_pkg::trust_mode_e       mode;
  logic [N_WR-1:0]            wr_en;
  logic [ENTRIES*CTR_W-1:0]   tbl;

  assign mode  = bias_mode ? cnf_pkg::MODE_GUARDED : cnf_pkg::MODE_BALANCED;
  assign wr_en = up_valid & up_load;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    cnf_entry #(
      .IDX_W(IDX_W), .N_WR(N_WR), .CTR_W(CTR_W), .BIAS_DEC(BIAS_DEC), .SLOT(e)
    ) u_ent (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .wr_en(wr_en), .wr_idx(up_idx), .wr_ok(up_correct),
      .ctr_q(tbl[e*CTR_W +: CTR_W])
    );
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    cnf_read_port #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .req_valid(lk_valid[r]), .req_load(lk_load[r]),
      .req_idx(lk_idx[r*IDX_W +: IDX_W]), .tbl(tbl),
      .rsp_valid(rsp_valid[r]), .rsp_trust(rsp_trust[r])
    );
  end
endmodule

// File: rtl/cnf_table_chk.sv
module cnf_table_chk #(
  parameter int IDX_W = 8,
  parameter int N_RD  = 2,
  parameter int N_WR  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bias_mode,
  input logic [N_RD-1:0]       lk_valid,
  input logic [N_RD-1:0]       lk_load,
  input logic [N_RD*IDX_W-1:0] lk_idx,
  input logic [N_RD-1:0]       rsp_valid,
  input logic [N_RD-1:0]       rsp_trust,
  input logic [N_WR-1:0]       up_valid,
  input logic [N_WR-1:0]       up_load
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_port
    p_rsp_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      rsp_valid[i] == $past(lk_valid[i] && lk_load[i]));

    p_trust_needs_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trust[i] |-> rsp_valid[i]);
  end

  // same entry, same mode, no update in between: the answer repeats (R9)
  p_hold_without_update_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (lk_valid[0] && lk_load[0] && $past(lk_valid[0] && lk_load[0]) &&
     (lk_idx[IDX_W-1:0] == $past(lk_idx[IDX_W-1:0])) &&
     !$past(|(up_valid & up_load)) && $stable(bias_mode))
    |=> $stable(rsp_trust[0]));

  if (N_RD >= 2) begin : g_pair
    p_same_idx_agree_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(lk_valid[0] && lk_load[0] && lk_valid[1] && lk_load[1] &&
             (lk_idx[IDX_W-1:0] == lk_idx[2*IDX_W-1:IDX_W])))
      |-> (rsp_trust[0] == rsp_trust[1]));
  end
endmodule

bind conf_trust_table cnf_table_chk #(.IDX_W(IDX_W), .N_RD(N_RD), .N_WR(N_WR)) u_chk (.*);

// File: tb/conf_trust_table_test.sv
module conf_trust_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int N_RD  = 2;
  localparam int N_WR  = 2;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  bias_mode = 1'b0;
  logic [N_RD-1:0]       lk_valid, lk_load, rsp_valid, rsp_trust;
  logic [N_RD*IDX_W-1:0] lk_idx;
  logic [N_WR-1:0]       up_valid, up_load, up_correct;
  logic [N_WR*IDX_W-1:0] up_idx;

  int checks = 0;
  int errors = 0;

  conf_trust_table #(.IDX_W(IDX_W), .N_RD(N_RD), .N_WR(N_WR)) uut (
    .clk(clk), .rst_n(rst_n), .bias_mode(bias_mode),
    .lk_valid(lk_valid), .lk_load(lk_load), .lk_idx(lk_idx),
    .rsp_valid(rsp_valid), .rsp_trust(rsp_trust),
    .up_valid(up_valid), .up_load(up_load), .up_idx(up_idx), .up_correct(up_correct)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {bias_mode, entry, outcome, expected trust after the update}
  localparam logic [6:0] VEC [18] = '{
    {1'b0, 4'd3, 1'b1, 1'b0}, {1'b0, 4'd3, 1'b1, 1'b1}, {1'b0, 4'd3, 1'b1, 1'b1},
    {1'b0, 4'd3, 1'b1, 1'b1}, {1'b0, 4'd3, 1'b0, 1'b1}, {1'b0, 4'd3, 1'b0, 1'b0},
    {1'b0, 4'd3, 1'b0, 1'b0}, {1'b0, 4'd3, 1'b0, 1'b0},
    {1'b1, 4'd5, 1'b1, 1'b0}, {1'b1, 4'd5, 1'b1, 1'b0}, {1'b1, 4'd5, 1'b1, 1'b1},
    {1'b1, 4'd5, 1'b1, 1'b1}, {1'b1, 4'd5, 1'b0, 1'b0}, {1'b1, 4'd5, 1'b0, 1'b0},
    {1'b1, 4'd5, 1'b1, 1'b0}, {1'b1, 4'd5, 1'b1, 1'b0}, {1'b1, 4'd5, 1'b0, 1'b0},
    {1'b1, 4'd5, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = '0; lk_load = '0; lk_idx = '0;
    up_valid = '0; up_load = '0; up_idx = '0; up_correct = '0;
  endtask

  task automatic put_up(input int p, input logic [IDX_W-1:0] idx, input logic ok, input logic ld);
    up_valid[p] = 1'b1; up_load[p] = ld; up_correct[p] = ok;
    up_idx[p*IDX_W +: IDX_W] = idx;
  endtask

  task automatic put_lk(input int p, input logic [IDX_W-1:0] idx, input logic ld);
    lk_valid[p] = 1'b1; lk_load[p] = ld;
    lk_idx[p*IDX_W +: IDX_W] = idx;
  endtask

  task automatic train(input logic md, input int p, input logic [IDX_W-1:0] idx, input logic ok);
    idle(); bias_mode = md; put_up(p, idx, ok, 1'b1);
    @(negedge clk); idle();
  endtask

  task automatic probe(input string req, input logic md, input int p,
                       input logic [IDX_W-1:0] idx, input logic exp);
    idle(); bias_mode = md; put_lk(p, idx, 1'b1);
    @(negedge clk); idle();
    chk(req, "rsp_valid", rsp_valid[p], 1'b1);
    chk(req, "rsp_trust", rsp_trust[p], exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fresh table is untrusted, idle ports silent
    chk("R1", "idle rsp_valid", |rsp_valid, 1'b0);
    probe("R1", 1'b0, 0, 4'd0, 1'b0);
    probe("R1", 1'b1, 1, 4'd15, 1'b0);

    // R2 R3 R4 R5: vector walk, one update then one lookup per vector
    for (int v = 0; v < 18; v++) begin
      train(VEC[v][6], 0, VEC[v][5:2], VEC[v][1]);
      probe(VEC[v][6] ? "R4/R5 vec" : "R2/R3 vec", VEC[v][6], v % 2, VEC[v][5:2], VEC[v][0]);
    end

    // R11: entry 5 now holds 1; one guarded correct makes it 2
    train(1'b1, 0, 4'd5, 1'b1);
    probe("R11", 1'b0, 0, 4'd5, 1'b1);
    probe("R11", 1'b1, 0, 4'd5, 1'b0);
    probe("R11", 1'b0, 1, 4'd5, 1'b1);

    // R7: entry 9 trained to 2, then lookup and wrong update together
    train(1'b0, 0, 4'd9, 1'b1);
    train(1'b0, 1, 4'd9, 1'b1);
    idle(); bias_mode = 1'b0; put_up(0, 4'd9, 1'b0, 1'b1); put_lk(0, 4'd9, 1'b1);
    @(negedge clk); idle();
    chk("R7", "pre-update trust", rsp_trust[0], 1'b1);
    probe("R7", 1'b0, 0, 4'd9, 1'b0);

    // R8: entry 11 at 3, guarded: port0 correct then port1 wrong gives 1
    train(1'b1, 0, 4'd11, 1'b1);
    train(1'b1, 0, 4'd11, 1'b1);
    train(1'b1, 0, 4'd11, 1'b1);
    idle(); bias_mode = 1'b1; put_up(0, 4'd11, 1'b1, 1'b1); put_up(1, 4'd11, 1'b0, 1'b1);
    @(negedge clk); idle();
    probe("R8", 1'b0, 0, 4'd11, 1'b0);
    train(1'b1, 0, 4'd11, 1'b1);
    probe("R8", 1'b0, 0, 4'd11, 1'b1);

    // R8: both update ports on different entries in one cycle
    idle(); bias_mode = 1'b0; put_up(0, 4'd12, 1'b1, 1'b1); put_up(1, 4'd14, 1'b1, 1'b1);
    @(negedge clk);
    idle(); bias_mode = 1'b0; put_up(0, 4'd12, 1'b1, 1'b1); put_up(1, 4'd14, 1'b1, 1'b1);
    @(negedge clk); idle();
    probe("R8", 1'b0, 0, 4'd12, 1'b1);
    probe("R8", 1'b0, 1, 4'd14, 1'b1);

    // R9: non-load lookups and updates
    idle(); put_lk(0, 4'd12, 1'b0); put_lk(1, 4'd12, 1'b0);
    @(negedge clk); idle();
    chk("R9", "non-load rsp_valid", |rsp_valid, 1'b0);
    chk("R9", "non-load rsp_trust", |rsp_trust, 1'b0);
    for (int k = 0; k < 3; k++) begin
      idle(); bias_mode = 1'b0; put_up(0, 4'd13, 1'b1, 1'b0); put_up(1, 4'd13, 1'b1, 1'b0);
      @(negedge clk);
    end
    idle();
    probe("R9", 1'b0, 0, 4'd13, 1'b0);

    // R10: both lookup ports, same and different entries
    idle(); bias_mode = 1'b0; put_lk(0, 4'd12, 1'b1); put_lk(1, 4'd12, 1'b1);
    @(negedge clk); idle();
    chk("R10", "same idx port0", rsp_trust[0], 1'b1);
    chk("R10", "same idx port1", rsp_trust[1], 1'b1);
    idle(); bias_mode = 1'b0; put_lk(0, 4'd12, 1'b1); put_lk(1, 4'd3, 1'b1);
    @(negedge clk); idle();
    chk("R10", "split port0", rsp_trust[0], 1'b1);
    chk("R10", "split port1", rsp_trust[1], 1'b0);

    // R1: reset clears trained entries
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R1", 1'b0, 0, 4'd12, 1'b0);

    finish_run();
  end
endmodule